// File: doc/BRIEF.md
# PLL Setting Lookup and Output-Rate Calculator

This block keeps a small register table of the output frequencies a clock synthesizer supports. Each entry pairs a rate with the four settings that produce it: reference divider, output divider, feedback multiplier and loop-bandwidth code. Software or a sequencer loads the table through a write port, one entry per cycle. Entries are held in descending rate order. A zero rate marks the end of the valid part of the table.

A request carries one of three operations. An exact query looks for the entry whose rate equals the key and returns that entry's settings, or a miss. A round-down query returns the largest supported rate that does not exceed the key. If every entry lies above the key, it falls back to the smallest supported rate. A calculate request takes an input frequency and the raw divider fields, each of which holds its value minus one. It returns the resulting output frequency, or the input frequency unchanged when bypass is requested. Queries scan the table one entry per clock. Calculations run through a bit-serial divider. Either way the result appears with a single-cycle `done` pulse.

Top module: `pll_rate_lookup`

## Requirements
- R1: The valid entries are those from index 0 up to, but not including, the first entry whose rate is zero. An entry after that terminator is never returned by either query type.
- R2: A round-down query (`req_op` = 2'b01) scans from index 0. It returns, with `res_hit`=1, the first valid entry whose rate is less than or equal to the key.
- R3: When no valid entry is less than or equal to the key, a round-down query returns the last valid entry (the minimum supported rate) with `res_hit`=1.
- R4: An exact query (`req_op` = 2'b00) returns `res_hit`=1 with the rate, reference divider, output divider, multiplier and bandwidth code of the entry whose rate equals the key. If no valid entry matches, it returns `res_hit`=0.
- R5: A calculate request (`req_op[1]`=1, `req_bypass`=0) returns `res_hit`=1 and `res_rate` = floor(floor(`req_rate`·(`req_nf`+1) / (`req_nr`+1)) / (`req_no`+1)). The product is formed on an `ACC_W`-bit intermediate.
- R6: A calculate request with `req_bypass`=1 returns `res_rate` = `req_rate`, whatever the divider fields hold. `done` rises at the first clock edge after acceptance.
- R7: The scan examines one entry per clock. A query that ends while examining index k raises `done` k+1 edges after the accepting edge. `done` is high for exactly one cycle per request.
- R8: A request is accepted only while `busy` is low. A request presented while `busy` is high is ignored: it neither alters the result in progress nor produces a `done`.
- R9: When the table is empty (entry 0 has rate zero), both exact and round-down queries return `res_hit`=0.
- R10: After reset, `done` and `busy` are low and every table rate is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_rate | input | RATE_W | Rate to store (zero terminates the table) |
| tbl_nr | input | NR_W | Reference divider setting to store |
| tbl_no | input | NO_W | Output divider setting to store |
| tbl_nf | input | NF_W | Feedback multiplier setting to store |
| tbl_bw | input | BW_W | Bandwidth code to store |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 00 exact, 01 round-down, 1x calculate |
| req_rate | input | RATE_W | Query key, or input frequency for calculate |
| req_nr | input | NR_W | Raw reference divider field (value minus one) |
| req_no | input | NO_W | Raw output divider field (value minus one) |
| req_nf | input | NF_W | Raw multiplier field (value minus one) |
| req_bypass | input | 1 | Calculate returns the input frequency |
| busy | output | 1 | Request in progress or result cycle |
| done | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Entry found / calculation valid |
| res_rate | output | RATE_W | Returned rate or computed frequency |
| res_nr | output | NR_W | Returned reference divider setting |
| res_no | output | NO_W | Returned output divider setting |
| res_nf | output | NF_W | Returned multiplier setting |
| res_bw | output | BW_W | Returned bandwidth code |

## Verification
The bench builds the block with its default parameters: eight table slots, 32-bit rates and a 64-bit intermediate. With eight slots, a five-entry table can be followed by a zero terminator and then a stray non-zero entry, so the bench can show that the terminator bounds both searches and the floor fallback. The 64-bit intermediate lets a 24 MHz input be multiplied by large feedback values without loss. It also holds a case where the two successive floor divisions round down.

// File: rtl/pll_rate_lookup.sv
module pll_rate_lookup #(
  parameter int DEPTH  = 8,
  parameter int RATE_W = 32,
  parameter int NR_W   = 6,
  parameter int NO_W   = 4,
  parameter int NF_W   = 13,
  parameter int BW_W   = 12,
  parameter int ACC_W  = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [RATE_W-1:0] tbl_rate,
  input  logic [NR_W-1:0]   tbl_nr,
  input  logic [NO_W-1:0]   tbl_no,
  input  logic [NF_W-1:0]   tbl_nf,
  input  logic [BW_W-1:0]   tbl_bw,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [RATE_W-1:0] req_rate,
  input  logic [NR_W-1:0]   req_nr,
  input  logic [NO_W-1:0]   req_no,
  input  logic [NF_W-1:0]   req_nf,
  input  logic              req_bypass,
  output logic              busy,
  output logic              done,
  output logic              res_hit,
  output logic [RATE_W-1:0] res_rate,
  output logic [NR_W-1:0]   res_nr,
  output logic [NO_W-1:0]   res_no,
  output logic [NF_W-1:0]   res_nf,
  output logic [BW_W-1:0]   res_bw
);
  localparam int DEN_W = NR_W + NO_W + 1;
  localparam int CNT_W = $clog2(ACC_W);
  localparam logic [1:0] OP_EXACT = 2'd0;
  localparam logic [1:0] OP_ROUND = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DIV} st_t;

  st_t               state;
  logic [RATE_W-1:0] t_rate [DEPTH];
  logic [NR_W-1:0]   t_nr   [DEPTH];
  logic [NO_W-1:0]   t_no   [DEPTH];
  logic [NF_W-1:0]   t_nf   [DEPTH];
  logic [BW_W-1:0]   t_bw   [DEPTH];

  logic [1:0]        op_q;
  logic [RATE_W-1:0] key_q;
  logic [IDX_W-1:0]  idx;
  logic [DEN_W-1:0]  den_q, rem;
  logic [ACC_W-1:0]  quo;
  logic [CNT_W-1:0]  cnt;

  wire [RATE_W-1:0] cur_rate = t_rate[idx];
  wire              at_end   = (cur_rate == '0);
  wire              at_last  = (idx == IDX_W'(DEPTH - 1));
  wire              match    = (op_q == OP_EXACT) ? (cur_rate == key_q) : (cur_rate <= key_q);
  wire [IDX_W-1:0]  sel      = at_end ? idx - 1'b1 : idx;

  wire [DEN_W:0]    rem_sh = {rem, quo[ACC_W-1]};
  wire              ge     = (rem_sh >= {1'b0, den_q});
  wire [DEN_W-1:0]  rem_n  = ge ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
  wire [ACC_W-1:0]  quo_n  = {quo[ACC_W-2:0], ge};

  wire accept = req_valid && !busy;
  assign busy = (state != S_IDLE) || done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        t_rate[i] <= '0; t_nr[i] <= '0; t_no[i] <= '0; t_nf[i] <= '0; t_bw[i] <= '0;
      end
    end else if (tbl_we) begin
      t_rate[tbl_idx] <= tbl_rate;
      t_nr[tbl_idx]   <= tbl_nr;
      t_no[tbl_idx]   <= tbl_no;
      t_nf[tbl_idx]   <= tbl_nf;
      t_bw[tbl_idx]   <= tbl_bw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; done <= 1'b0; op_q <= '0; key_q <= '0; idx <= '0;
      den_q <= '0; rem <= '0; quo <= '0; cnt <= '0;
      res_hit <= 1'b0; res_rate <= '0; res_nr <= '0; res_no <= '0; res_nf <= '0; res_bw <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          op_q  <= req_op;
          key_q <= req_rate;
          idx   <= '0;
          if (!req_op[1]) begin
            state <= S_SCAN;
          end else if (req_bypass) begin
            done <= 1'b1; res_hit <= 1'b1; res_rate <= req_rate;
            res_nr <= '0; res_no <= '0; res_nf <= '0; res_bw <= '0;
          end else begin
            state <= S_DIV;
            quo   <= ACC_W'(req_rate) * ACC_W'({1'b0, req_nf} + 1'b1);
            den_q <= DEN_W'({1'b0, req_nr} + 1'b1) * DEN_W'({1'b0, req_no} + 1'b1);
            rem   <= '0;
            cnt   <= '0;
          end
        end
        S_SCAN: begin
          if (at_end || match || at_last) begin
            state <= S_IDLE;
            done  <= 1'b1;
            if ((at_end && (idx == '0 || op_q == OP_EXACT)) || (!at_end && !match && op_q == OP_EXACT)) begin
              res_hit <= 1'b0; res_rate <= '0;
              res_nr <= '0; res_no <= '0; res_nf <= '0; res_bw <= '0;
            end else begin
              res_hit  <= 1'b1;
              res_rate <= t_rate[sel];
              res_nr   <= t_nr[sel];
              res_no   <= t_no[sel];
              res_nf   <= t_nf[sel];
              res_bw   <= t_bw[sel];
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_DIV: begin
          rem <= rem_n;
          quo <= quo_n;
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(ACC_W - 1)) begin
            state <= S_IDLE; done <= 1'b1; res_hit <= 1'b1;
            res_rate <= quo_n[RATE_W-1:0];
            res_nr <= '0; res_no <= '0; res_nf <= '0; res_bw <= '0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_single_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_scan_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SCAN && $past(state) == S_SCAN) |-> idx == IDX_W'($past(idx) + 1'b1));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_q) && $stable(key_q)));

  assert_exact_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_hit && op_q == OP_EXACT) |-> res_rate == key_q);

  assert_round_miss_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_hit && op_q == OP_ROUND) |-> t_rate[0] == '0);

  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state != S_IDLE || accept));
endmodule

// File: tb/pll_rate_lookup_bench.sv
`timescale 1ns/1ps
module pll_rate_lookup_bench;
  localparam int IDX_W = 3;
  logic clk = 0, rst_n = 0;
  logic tbl_we = 0; logic [IDX_W-1:0] tbl_idx = 0; logic [31:0] tbl_rate = 0;
  logic [5:0] tbl_nr = 0; logic [3:0] tbl_no = 0; logic [12:0] tbl_nf = 0; logic [11:0] tbl_bw = 0;
  logic req_valid = 0; logic [1:0] req_op = 0; logic [31:0] req_rate = 0;
  logic [5:0] req_nr = 0; logic [3:0] req_no = 0; logic [12:0] req_nf = 0; logic req_bypass = 0;
  logic busy, done, res_hit; logic [31:0] res_rate;
  logic [5:0] res_nr; logic [3:0] res_no; logic [12:0] res_nf; logic [11:0] res_bw;
  int n_chk = 0, n_bad = 0, lat;

  always #4 clk = ~clk;

  pll_rate_lookup u_pll_rate_lookup (.*);

  // {op, key, hit, rate}
  localparam logic [66:0] VEC [10] = '{
    {2'd0, 32'd1000, 1'b1, 32'd1000},
    {2'd0, 32'd700,  1'b0, 32'd0},
    {2'd0, 32'd100,  1'b1, 32'd100},
    {2'd1, 32'd1100, 1'b1, 32'd1000},
    {2'd1, 32'd5000, 1'b1, 32'd1200},
    {2'd1, 32'd600,  1'b1, 32'd600},
    {2'd1, 32'd599,  1'b1, 32'd300},
    {2'd1, 32'd50,   1'b1, 32'd100},
    {2'd0, 32'd50,   1'b0, 32'd0},
    {2'd1, 32'd0,    1'b1, 32'd100}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int i, input int r, input int nr, input int no, input int nf, input int bw);
    @(negedge clk);
    tbl_we = 1; tbl_idx = IDX_W'(i); tbl_rate = 32'(r);
    tbl_nr = 6'(nr); tbl_no = 4'(no); tbl_nf = 13'(nf); tbl_bw = 12'(bw);
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic run(input logic [1:0] op, input logic [31:0] key, input int nr, input int no,
                     input int nf, input logic byp);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1; req_op = op; req_rate = key;
    req_nr = 6'(nr); req_no = 4'(no); req_nf = 13'(nf); req_bypass = byp;
    @(negedge clk); req_valid = 0;
    lat = 0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    if (!done) check("watchdog request", 0, 1);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 done after reset", done, 0);
    check("R10 busy after reset", busy, 0);
    rst_n = 1;
    run(2'd0, 32'd1000, 0, 0, 0, 0);
    check("R10 R9 exact on empty table", res_hit, 0);
    run(2'd1, 32'd1000, 0, 0, 0, 0);
    check("R9 round on empty table", res_hit, 0);

    wr(0, 1200, 1, 1, 99, 49);
    wr(1, 1000, 2, 1, 124, 62);
    wr(2, 600, 3, 2, 149, 74);
    wr(3, 300, 1, 4, 24, 12);
    wr(4, 100, 1, 3, 16, 8);
    wr(6, 50, 5, 5, 5, 5);

    for (int v = 0; v < 10; v++) begin
      run(VEC[v][66:65], VEC[v][64:33], 0, 0, 0, 0);
      check($sformatf("R1 R2 R3 R4 vector %0d hit", v), res_hit, VEC[v][32]);
      check($sformatf("R1 R2 R3 R4 vector %0d rate", v), res_rate, VEC[v][31:0]);
    end

    run(2'd0, 32'd600, 0, 0, 0, 0);
    check("R4 exact nr", res_nr, 3);
    check("R4 exact no", res_no, 2);
    check("R4 exact nf", res_nf, 149);
    check("R4 exact bw", res_bw, 74);
    check("R7 latency idx2", lat, 3);
    @(negedge clk);
    check("R7 done one cycle", done, 0);

    run(2'd0, 32'd1200, 0, 0, 0, 0);
    check("R7 latency idx0", lat, 1);
    run(2'd1, 32'd50, 0, 0, 0, 0);
    check("R3 fallback nr", res_nr, 1);
    check("R7 R1 latency to terminator", lat, 6);

    run(2'd2, 32'd24000000, 1, 1, 99, 0);
    check("R5 calc 24M*100/2/2", res_rate, 600000000);
    run(2'd2, 32'd24000000, 0, 0, 63, 0);
    check("R5 calc 24M*64", res_rate, 1536000000);
    run(2'd2, 32'd1000, 6, 1, 2, 0);
    check("R5 calc floors 3000/7/2", res_rate, 214);
    check("R5 calc hit", res_hit, 1);
    run(2'd3, 32'd777, 6, 1, 2, 1);
    check("R6 bypass rate", res_rate, 777);
    check("R6 bypass latency", lat, 0);

    begin
      int dones = 0;
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1; req_op = 2'd2; req_rate = 32'd24000000;
      req_nr = 1; req_no = 1; req_nf = 99; req_bypass = 0;
      @(negedge clk); req_valid = 0;
      repeat (3) @(negedge clk);
      req_valid = 1; req_op = 2'd0; req_rate = 32'd1200;
      repeat (2) @(negedge clk);
      req_valid = 0;
      for (int c = 0; c < 100; c++) begin
        if (done) dones++;
        @(negedge clk);
      end
      check("R8 single done while busy", dones, 1);
      check("R8 result of first request", res_rate, 600000000);
    end

    wr(0, 0, 0, 0, 0, 0);
    run(2'd1, 32'd5000, 0, 0, 0, 0);
    check("R9 round after emptying", res_hit, 0);
    run(2'd0, 32'd1000, 0, 0, 0, 0);
    check("R9 exact after emptying", res_hit, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule